// File: doc/BRIEF.md
# FIFO Ready-Threshold Flag Generator

This block drives the two ready flags for one port's FIFO pair. The receive flag tells a consumer that the receive FIFO holds enough data to be worth draining. The transmit flag tells a producer that the transmit FIFO has enough room to be worth filling. Both FIFOs are counted in 32-bit double words. The block keeps an 8-bit threshold register that is loaded through a single-cycle write strobe. It compares the receive fill count and the transmit free-space count against the two 4-bit fields of that register, and it registers the results before they leave the block.

The FIFO storage, the host bus and any DMA logic sit outside this block. The surrounding logic supplies the counts every cycle and uses the flags as level-sensitive requests. The asynchronous reset is synchronised locally before it is released.

Top module: `fifo_rdy_thresh`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `rx_rdy` and `tx_rdy` are 0. The threshold register resets to 0x11, so both minimums are 1 double word.
- R2: Register bits 7:4 hold the receive minimum. `rx_rdy` is 1 exactly when `rx_fill_dw` is greater than or equal to that minimum.
- R3: Register bits 3:0 hold the transmit minimum. `tx_rdy` is 1 exactly when `tx_free_dw` is greater than or equal to that minimum.
- R4: A field value of 0 acts as 1. A count of 0 therefore never raises either flag, and a count of 1 raises it.
- R5: A write with `thr_wr_en`=1 loads `thr_wr_data` at the clock edge. The flags computed at the following edge use the new value, while the flag computed at the write edge still uses the old value. With `thr_wr_en`=0 the register holds its value.
- R6: Both flags are registered. A change in a count shows on the flag one clock edge later, and this applies to deassertion as well as assertion.
- R7: The two fields are independent. Writing a different receive field leaves `tx_rdy` unchanged for an unchanged transmit count, and the reverse also holds.
- R8: Counts span 0 to 16 (5 bits). A count of 16 meets the largest threshold, 15, and a count of 14 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr_en | input | 1 | Threshold register write strobe |
| thr_wr_data | input | 8 | Write data: [7:4] receive minimum, [3:0] transmit minimum |
| rx_fill_dw | input | 5 | Double words held in the receive FIFO |
| tx_free_dw | input | 5 | Free double-word slots in the transmit FIFO |
| rx_rdy | output | 1 | Receive data-available flag (registered) |
| tx_rdy | output | 1 | Transmit space-available flag (registered) |

## Verification
The bench sweeps each count through every value on both sides of a threshold. A design that used a strict greater-than would miss the equal case, and one that truncated the count to 4 bits would fail at 16. A zero field is programmed while the counts are 0 and 1: a design that compared literally would raise a flag on an empty FIFO. The bench samples the flag one edge after a write and again one edge later, which exposes a register that applies the write too early or too late. It also checks that changing one nibble leaves the other flag alone, which catches swapped or shared fields.

// File: rtl/fifo_rdy_thresh_pkg.sv
package fifo_rdy_thresh_pkg;
  localparam int THR_W = 4;
  localparam int REG_W = 2 * THR_W;
  localparam logic [REG_W-1:0] THR_RESET = 8'h11;

  typedef struct packed {
    logic [THR_W-1:0] rx_min;
    logic [THR_W-1:0] tx_min;
  } thr_reg_t;
endpackage

// File: rtl/frt_rst_sync.sv
module frt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/frt_thr_reg.sv
module frt_thr_reg
  import fifo_rdy_thresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output thr_reg_t         thr
);
  thr_reg_t thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = thr_reg_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= thr_reg_t'(THR_RESET);
    else        thr_q <= thr_d;
  end

  assign thr = thr_q;

  // R5
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (thr_q == $past(wr_data)));

  // R5
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(thr_q));
endmodule

// File: rtl/frt_level_cmp.sv
module frt_level_cmp #(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic [THR_W-1:0] min_level,
  output logic             rdy
);
  logic [CNT_W-1:0] eff_min;
  logic             rdy_d, rdy_q;

  always_comb begin
    eff_min = CNT_W'(min_level);
    if (min_level == '0) eff_min = CNT_W'(1);
    rdy_d = (level >= eff_min);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign rdy = rdy_q;

  // R4
  empty_never_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> !rdy_q);

  // R6
  fall_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level < CNT_W'(min_level)) |=> !rdy_q);

  // R6
  rise_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((level >= CNT_W'(min_level)) && (level != '0)) |=> rdy_q);
endmodule

// File: rtl/fifo_rdy_thresh.sv
module fifo_rdy_thresh
  import fifo_rdy_thresh_pkg::*;
#(
  parameter int FIFO_DW_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DW_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr_en,
  input  logic [REG_W-1:0] thr_wr_data,
  input  logic [CNT_W-1:0] rx_fill_dw,
  input  logic [CNT_W-1:0] tx_free_dw,
  output logic             rx_rdy,
  output logic             tx_rdy
);
  localparam int NCH = 2;

  logic     rst_sync_n;
  thr_reg_t thr;
  logic [NCH-1:0][CNT_W-1:0] lvl;
  logic [NCH-1:0][THR_W-1:0] mins;
  logic [NCH-1:0]            rdys;

  frt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  frt_thr_reg u_thr (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(thr_wr_en),
    .wr_data(thr_wr_data), .thr(thr)
  );

  assign lvl[0]  = rx_fill_dw;
  assign mins[0] = thr.rx_min;
  assign lvl[1]  = tx_free_dw;
  assign mins[1] = thr.tx_min;

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    frt_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
      .clk(clk), .rst_n(rst_sync_n), .level(lvl[g]),
      .min_level(mins[g]), .rdy(rdys[g])
    );
  end

  assign rx_rdy = rdys[0];
  assign tx_rdy = rdys[1];

  // R1
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      reset_flags_low_chk: assert (!rx_rdy && !tx_rdy);
    end
  end

  // R2
  rx_meets_min_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_rdy |-> ($past(rx_fill_dw) >= CNT_W'($past(thr.rx_min))));

  // R3
  tx_meets_min_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_rdy |-> ($past(tx_free_dw) >= CNT_W'($past(thr.tx_min))));
endmodule

// File: tb/fifo_rdy_thresh_tb.sv
module fifo_rdy_thresh_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       thr_wr_en;
  logic [7:0] thr_wr_data;
  logic [4:0] rx_fill_dw, tx_free_dw;
  logic       rx_rdy, tx_rdy;

  int n_checks = 0;
  int n_fails  = 0;
  logic [3:0] m_rx = 4'd1, m_tx = 4'd1;

  always #4 clk = ~clk;

  fifo_rdy_thresh u_dut (
    .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .rx_fill_dw(rx_fill_dw), .tx_free_dw(tx_free_dw), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy)
  );

  function automatic logic model_rdy(input logic [4:0] c, input logic [3:0] m);
    int e = (m == 0) ? 1 : int'(m);
    return int'(c) >= e;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one edge with inputs already set at negedge; sample at following negedge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_thr(input logic [7:0] v);
    thr_wr_en = 1'b1; thr_wr_data = v;
    step();
    thr_wr_en = 1'b0;
    m_rx = v[7:4]; m_tx = v[3:0];
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rx_fill_dw = 5'd16; tx_free_dw = 5'd16;
    repeat (3) step();
    chk("R1 rx during reset", rx_rdy, 1'b0);
    chk("R1 tx during reset", tx_rdy, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 rx after release", rx_rdy, 1'b0);
    repeat (3) step();
    rx_fill_dw = 5'd0; tx_free_dw = 5'd0; step();
    chk("R1 rx reset min 1 at 0", rx_rdy, 1'b0);
    rx_fill_dw = 5'd1; tx_free_dw = 5'd1; step();
    chk("R1 rx reset min 1 at 1", rx_rdy, 1'b1);
    chk("R1 tx reset min 1 at 1", tx_rdy, 1'b1);
  endtask

  task automatic t_rx_sweep(input logic [3:0] m);
    write_thr({m, 4'd1});
    tx_free_dw = 5'd0;
    for (int c = 0; c <= 16; c++) begin
      rx_fill_dw = 5'(c); step();
      chk("R2 rx sweep", rx_rdy, model_rdy(5'(c), m));
    end
  endtask

  task automatic t_tx_sweep(input logic [3:0] m);
    write_thr({4'd1, m});
    rx_fill_dw = 5'd0;
    for (int c = 0; c <= 16; c++) begin
      tx_free_dw = 5'(c); step();
      chk("R3 tx sweep", tx_rdy, model_rdy(5'(c), m));
    end
  endtask

  task automatic t_zero();
    write_thr(8'h00);
    rx_fill_dw = 5'd0; tx_free_dw = 5'd0; step();
    chk("R4 rx zero min empty", rx_rdy, 1'b0);
    chk("R4 tx zero min empty", tx_rdy, 1'b0);
    rx_fill_dw = 5'd1; tx_free_dw = 5'd1; step();
    chk("R4 rx zero min one", rx_rdy, 1'b1);
    chk("R4 tx zero min one", tx_rdy, 1'b1);
  endtask

  task automatic t_write_timing();
    write_thr(8'h22);
    rx_fill_dw = 5'd3; tx_free_dw = 5'd3; step();
    chk("R5 rx before write", rx_rdy, 1'b1);
    thr_wr_en = 1'b1; thr_wr_data = 8'h88;
    step();
    thr_wr_en = 1'b0; thr_wr_data = 8'h00;
    chk("R5 rx at write edge uses old", rx_rdy, 1'b1);
    chk("R5 tx at write edge uses old", tx_rdy, 1'b1);
    step();
    chk("R5 rx next edge uses new", rx_rdy, 1'b0);
    chk("R5 tx next edge uses new", tx_rdy, 1'b0);
    m_rx = 4'd8; m_tx = 4'd8;
    rx_fill_dw = 5'd8; tx_free_dw = 5'd8;
    repeat (3) step();
    chk("R5 rx held without write", rx_rdy, 1'b1);
    chk("R5 tx held without write", tx_rdy, 1'b1);
  endtask

  task automatic t_latency();
    write_thr(8'h44);
    rx_fill_dw = 5'd4; step();
    chk("R6 rx high", rx_rdy, 1'b1);
    rx_fill_dw = 5'd3;
    @(posedge clk); #1;
    chk("R6 rx still high just after edge? no: registered change", rx_rdy, 1'b0);
    @(negedge clk);
    tx_free_dw = 5'd4;
    @(posedge clk); #1;
    chk("R6 tx rises one edge after", tx_rdy, 1'b1);
    @(negedge clk);
    tx_free_dw = 5'd2;
    #1;
    chk("R6 tx no change before edge", tx_rdy, 1'b1);
    step();
    chk("R6 tx falls after edge", tx_rdy, 1'b0);
  endtask

  task automatic t_independent();
    write_thr(8'h55);
    rx_fill_dw = 5'd5; tx_free_dw = 5'd5; step();
    write_thr(8'hF5);
    chk("R7 tx unchanged by rx field", tx_rdy, 1'b1);
    chk("R7 rx follows own field", rx_rdy, 1'b0);
    write_thr(8'h1F);
    chk("R7 rx unaffected by tx field", rx_rdy, 1'b1);
    chk("R7 tx follows own field", tx_rdy, 1'b0);
  endtask

  task automatic t_full_range();
    write_thr(8'hFF);
    rx_fill_dw = 5'd16; tx_free_dw = 5'd16; step();
    chk("R8 rx 16 meets 15", rx_rdy, 1'b1);
    chk("R8 tx 16 meets 15", tx_rdy, 1'b1);
    rx_fill_dw = 5'd14; tx_free_dw = 5'd14; step();
    chk("R8 rx 14 below 15", rx_rdy, 1'b0);
    chk("R8 tx 14 below 15", tx_rdy, 1'b0);
  endtask

  initial begin
    thr_wr_en = 1'b0; thr_wr_data = 8'h00;
    rx_fill_dw = 5'd0; tx_free_dw = 5'd0; rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx_sweep(4'd1);
    t_rx_sweep(4'd7);
    t_rx_sweep(4'd15);
    t_tx_sweep(4'd2);
    t_tx_sweep(4'd12);
    t_zero();
    t_write_timing();
    t_latency();
    t_independent();
    t_full_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule